// File: doc/BRIEF.md
# Write-Once Structure Store with Deferred Readers

This block is a small structure memory for a dataflow machine. Each word is meant to be written once and then read any number of times. Reads are split-phase. A fetch request carries an address and a return tag, and the value comes back later as a separate reply token that carries the same tag. A fetch that reaches a word before its writer has arrived is neither an error nor a stall. The reader's tag is parked in a shared pool of waiting-reader entries, and these entries are linked into a per-word list in arrival order.

When a store later fills that word, the block walks the list. It emits one reply per waiting reader, one per cycle, in the order the readers arrived, and it returns each pool entry as it goes. Beyond the write-once fetch and store, the block also offers a destructive take, an overwriting put and a clear. The pool has a fixed size. When it is exhausted, only fetches that would have to wait are held off, by dropping the request-ready signal.

Top module: `wo_struct_mem`

## Requirements
- R1: After reset every word is empty, rspValid and errFlag are low, and reqReady is high.
- R2: Opcode 0 is a write-once fetch and opcode 1 is a write-once store. A store to an empty word fills it. A fetch accepted on a full word yields one reply in the following cycle, carrying the request's tag and the stored word, and the word stays full for further fetches.
- R3: A fetch accepted on a word that is not full produces no reply when it is accepted.
- R4: A store or put accepted on a word with waiting readers first spends one cycle with no reply. It then yields one reply per cycle, in the order the readers arrived, each carrying the written data. reqReady is low from the accepting edge until the last reply is presented.
- R5: A write-once store to a full word raises errFlag for exactly the following cycle and leaves the stored value unchanged.
- R6: Opcode 2 (take) on a full word replies next cycle with the tag and data and leaves the word empty. On a word that is not full, it produces no reply and raises errFlag for one cycle.
- R7: Opcode 3 (put) writes the word whatever its state, with no error, and leaves it full.
- R8: Opcode 4 (clear) leaves the word empty. Any readers waiting on it are dropped without replies, and their pool entries become free again.
- R9: The pool holds 4 waiting readers. While it is full, a fetch to a word that is not full sees reqReady low, and every other request still sees reqReady high.
- R10: Opcodes 5 to 7 are accepted and have no effect: no reply, no error, and no change to any word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request can be accepted this cycle |
| reqOp | input | 3 | Operation code |
| reqAddr | input | 4 | Word address |
| reqData | input | 64 | Write data for store and put |
| reqTag | input | 16 | Return tag for fetch and take |
| rspValid | output | 1 | Reply token present |
| rspTag | output | 16 | Tag of the reader being answered |
| rspData | output | 64 | Value returned |
| errFlag | output | 1 | One-cycle pulse on a rejected store or take |

## Verification
The bench builds a list of three early readers on one word and then releases it. A design that kept the list as a stack would answer the readers in reverse order. A design that let a new request in during the release would show reqReady high too early. The bench also issues a second write-once store, which must leave the first value readable. A design that ignored write-once would change what the next fetch returns. Finally, the bench fills the pool, checks that only the would-wait fetch is held off, then clears the waiting word. If the design leaked pool entries or answered the dropped readers, that would show as a stuck reqReady or as stray replies.

// File: rtl/istore_pkg.sv
package istore_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 64;
  localparam int TAG_W  = 16;
  localparam int POOL_W = 2;
  localparam int WORDS  = 1 << ADDR_W;
  localparam int POOL_N = 1 << POOL_W;

  typedef enum logic [2:0] {
    OP_IFETCH = 3'd0,
    OP_ISTORE = 3'd1,
    OP_TAKE   = 3'd2,
    OP_PUT    = 3'd3,
    OP_CLEAR  = 3'd4
  } opcode_e;

  typedef enum logic [1:0] {W_EMPTY, W_FULL, W_DEFER} wstate_e;

  typedef struct packed {
    logic              dataWe;
    logic [ADDR_W-1:0] addr;
    logic              tagWe;
    logic [POOL_W-1:0] newIdx;
    logic              linkWe;
    logic [POOL_W-1:0] linkIdx;
    logic              rspNow;
    logic              rspFromPool;
    logic [POOL_W-1:0] rdIdx;
    logic              latchStore;
  } strobe_t;
endpackage

// File: rtl/istore_ctrl.sv
module istore_ctrl
  import istore_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [POOL_W-1:0] nextIdx,
  output logic              reqReady,
  output strobe_t           strb,
  output logic              errFlag
);
  wstate_e           wState  [WORDS];
  logic [POOL_W-1:0] headIdx [WORDS];
  logic [POOL_W-1:0] tailIdx [WORDS];
  logic [POOL_N-1:0] poolBusy;
  logic              draining, silent;
  logic [POOL_W-1:0] curIdx, lastIdx, freeIdx;
  logic              poolFull, wantDefer, accept;
  logic              startDrain, startSilent, doAlloc, errNow;
  wstate_e           curState, nxtState;

  always_comb begin
    freeIdx = '0;
    for (int i = POOL_N - 1; i >= 0; i--)
      if (!poolBusy[i]) freeIdx = POOL_W'(i);
  end

  assign poolFull  = &poolBusy;
  assign curState  = wState[reqAddr];
  assign wantDefer = (reqOp == OP_IFETCH) && (curState != W_FULL);
  assign reqReady  = !draining && !(wantDefer && poolFull);
  assign accept    = reqValid && reqReady;

  always_comb begin
    strb         = '0;
    strb.addr    = reqAddr;
    strb.newIdx  = freeIdx;
    strb.linkIdx = tailIdx[reqAddr];
    strb.rdIdx   = curIdx;
    nxtState     = curState;
    startDrain   = 1'b0;
    startSilent  = 1'b0;
    doAlloc      = 1'b0;
    errNow       = 1'b0;
    if (draining) begin
      strb.rspNow      = !silent;
      strb.rspFromPool = 1'b1;
    end else if (accept) begin
      case (reqOp)
        OP_IFETCH:
          if (curState == W_FULL) strb.rspNow = 1'b1;
          else begin
            strb.tagWe  = 1'b1;
            strb.linkWe = (curState == W_DEFER);
            doAlloc     = 1'b1;
            nxtState    = W_DEFER;
          end
        OP_ISTORE:
          if (curState == W_FULL) errNow = 1'b1;
          else begin
            strb.dataWe     = 1'b1;
            strb.latchStore = 1'b1;
            nxtState        = W_FULL;
            startDrain      = (curState == W_DEFER);
          end
        OP_TAKE:
          if (curState == W_FULL) begin
            strb.rspNow = 1'b1;
            nxtState    = W_EMPTY;
          end else errNow = 1'b1;
        OP_PUT: begin
          strb.dataWe     = 1'b1;
          strb.latchStore = 1'b1;
          nxtState        = W_FULL;
          startDrain      = (curState == W_DEFER);
        end
        OP_CLEAR: begin
          nxtState    = W_EMPTY;
          startDrain  = (curState == W_DEFER);
          startSilent = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < WORDS; i++) begin
        wState[i]  <= W_EMPTY;
        headIdx[i] <= '0;
        tailIdx[i] <= '0;
      end
      poolBusy <= '0;
      draining <= 1'b0;
      silent   <= 1'b0;
      curIdx   <= '0;
      lastIdx  <= '0;
      errFlag  <= 1'b0;
    end else begin
      errFlag <= errNow;
      if (accept) begin
        wState[reqAddr] <= nxtState;
        if (doAlloc) begin
          poolBusy[freeIdx] <= 1'b1;
          tailIdx[reqAddr]  <= freeIdx;
          if (curState == W_EMPTY) headIdx[reqAddr] <= freeIdx;
        end
        if (startDrain) begin
          draining <= 1'b1;
          silent   <= startSilent;
          curIdx   <= headIdx[reqAddr];
          lastIdx  <= tailIdx[reqAddr];
        end
      end
      if (draining) begin
        poolBusy[curIdx] <= 1'b0;
        if (curIdx == lastIdx) draining <= 1'b0;
        else curIdx <= nextIdx;
      end
    end
  end

  logic anyDefer;
  always_comb begin
    anyDefer = 1'b0;
    for (int i = 0; i < WORDS; i++)
      if (wState[i] == W_DEFER) anyDefer = 1'b1;
  end

  AST_POOL_MATCHES_STATE: assert property (@(posedge clk) disable iff (!rstN)
    (!draining && !anyDefer) |-> (poolBusy == '0)); // R8
  AST_NO_POOL_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (accept && wantDefer) |-> !poolFull); // R9
  AST_WRITE_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    (accept && reqOp == OP_ISTORE && curState == W_FULL) |-> !strb.dataWe); // R5
  AST_WRITE_ONCE_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (accept && reqOp == OP_ISTORE && curState == W_FULL) |=> errFlag); // R5
  AST_NO_ACCEPT_IN_DRAIN: assert property (@(posedge clk) disable iff (!rstN)
    draining |-> !accept); // R4
  AST_DRAIN_FROM_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(draining) |-> $past(accept)); // R4
endmodule

// File: rtl/istore_dp.sv
module istore_dp
  import istore_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] reqData,
  input  logic [TAG_W-1:0]  reqTag,
  output logic [POOL_W-1:0] nextIdx,
  output logic              rspValid,
  output logic [TAG_W-1:0]  rspTag,
  output logic [DATA_W-1:0] rspData
);
  logic [DATA_W-1:0] mem     [WORDS];
  logic [TAG_W-1:0]  tagMem  [POOL_N];
  logic [POOL_W-1:0] nextMem [POOL_N];
  logic [DATA_W-1:0] drainData;

  assign nextIdx = nextMem[strb.rdIdx];

  always_ff @(posedge clk) begin
    if (strb.dataWe)     mem[strb.addr]       <= reqData;
    if (strb.tagWe)      tagMem[strb.newIdx]  <= reqTag;
    if (strb.linkWe)     nextMem[strb.linkIdx] <= strb.newIdx;
    if (strb.latchStore) drainData            <= reqData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspTag   <= '0;
      rspData  <= '0;
    end else begin
      rspValid <= strb.rspNow;
      if (strb.rspNow) begin
        if (strb.rspFromPool) begin
          rspTag  <= tagMem[strb.rdIdx];
          rspData <= drainData;
        end else begin
          rspTag  <= reqTag;
          rspData <= mem[strb.addr];
        end
      end
    end
  end

  AST_REPLY_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(strb.rspNow)); // R2
endmodule

// File: rtl/wo_struct_mem.sv
module wo_struct_mem
  import istore_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [2:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic [TAG_W-1:0]  reqTag,
  output logic              rspValid,
  output logic [TAG_W-1:0]  rspTag,
  output logic [DATA_W-1:0] rspData,
  output logic              errFlag
);
  strobe_t           strb;
  logic [POOL_W-1:0] nextIdx;

  istore_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddr(reqAddr), .nextIdx(nextIdx), .reqReady(reqReady),
    .strb(strb), .errFlag(errFlag)
  );

  istore_dp uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqData(reqData),
    .reqTag(reqTag), .nextIdx(nextIdx), .rspValid(rspValid),
    .rspTag(rspTag), .rspData(rspData)
  );
endmodule

// File: tb/tb_wo_struct_mem.sv
module tb_wo_struct_mem;
  import istore_pkg::*;

  logic clk = 1'b0;
  logic rstN, reqValid, reqReady, rspValid, errFlag;
  logic [2:0] reqOp;
  logic [ADDR_W-1:0] reqAddr;
  logic [DATA_W-1:0] reqData, rspData;
  logic [TAG_W-1:0] reqTag, rspTag;
  int nChecks = 0;
  int nFail = 0;

  always #10 clk = ~clk;

  wo_struct_mem dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqAddr(reqAddr), .reqData(reqData), .reqTag(reqTag),
    .rspValid(rspValid), .rspTag(rspTag), .rspData(rspData), .errFlag(errFlag)
  );

  typedef struct packed {
    logic [2:0]        op;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic [TAG_W-1:0]  tag;
    logic              expValid;
    logic [TAG_W-1:0]  expTag;
    logic [DATA_W-1:0] expData;
    logic              expErr;
  } vec_t;

  localparam int NVEC = 15;
  localparam vec_t VEC [NVEC] = '{
    '{3'd1, 4'd2, 64'hA1, 16'h0,  1'b0, 16'h0,  64'h0,  1'b0}, // R2 fill
    '{3'd0, 4'd2, 64'h0,  16'h11, 1'b1, 16'h11, 64'hA1, 1'b0}, // R2 read
    '{3'd0, 4'd2, 64'h0,  16'h12, 1'b1, 16'h12, 64'hA1, 1'b0}, // R2 read again
    '{3'd1, 4'd2, 64'hB2, 16'h0,  1'b0, 16'h0,  64'h0,  1'b1}, // R5 second store
    '{3'd0, 4'd2, 64'h0,  16'h13, 1'b1, 16'h13, 64'hA1, 1'b0}, // R5 value kept
    '{3'd3, 4'd2, 64'hC3, 16'h0,  1'b0, 16'h0,  64'h0,  1'b0}, // R7 put on full
    '{3'd2, 4'd2, 64'h0,  16'h14, 1'b1, 16'h14, 64'hC3, 1'b0}, // R6 take full
    '{3'd2, 4'd2, 64'h0,  16'h15, 1'b0, 16'h0,  64'h0,  1'b1}, // R6 take empty
    '{3'd3, 4'd3, 64'hD4, 16'h0,  1'b0, 16'h0,  64'h0,  1'b0}, // R7 put on empty
    '{3'd0, 4'd3, 64'h0,  16'h16, 1'b1, 16'h16, 64'hD4, 1'b0}, // R7 read back
    '{3'd6, 4'd3, 64'hE5, 16'h0,  1'b0, 16'h0,  64'h0,  1'b0}, // R10 unused op
    '{3'd0, 4'd3, 64'h0,  16'h17, 1'b1, 16'h17, 64'hD4, 1'b0}, // R10 no change
    '{3'd4, 4'd3, 64'h0,  16'h0,  1'b0, 16'h0,  64'h0,  1'b0}, // R8 clear
    '{3'd1, 4'd3, 64'hF6, 16'h0,  1'b0, 16'h0,  64'h0,  1'b0}, // R8 store after clear
    '{3'd0, 4'd3, 64'h0,  16'h18, 1'b1, 16'h18, 64'hF6, 1'b0}  // R8 read back
  };

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] op, input logic [3:0] addr, input logic [63:0] data, input logic [15:0] tag);
    @(negedge clk);
    reqOp = op; reqAddr = addr; reqData = data; reqTag = tag; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic expectReply(input string what, input logic [15:0] tag, input logic [63:0] data);
    chk(rspValid && rspTag == tag && rspData == data, what, {rspValid, 15'd0, rspTag, rspData[31:0]}, {1'b1, 15'd0, tag, data[31:0]});
  endtask

  task automatic expectNone(input string what);
    chk(!rspValid, what, 64'(rspValid), 64'd0);
  endtask

  initial begin
    #(200000 * 20);
    nFail++;
    $display("FAIL watchdog R1 actual=%h expected=%h", 64'd0, 64'd1);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    rstN = 1'b0; reqValid = 1'b0; reqOp = 3'd0; reqAddr = '0; reqData = '0; reqTag = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!rspValid && !errFlag && reqReady, "R1 reset outputs", {61'd0, rspValid, errFlag, reqReady}, 64'd1);

    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i].op, VEC[i].addr, VEC[i].data, VEC[i].tag);
      chk(rspValid == VEC[i].expValid && errFlag == VEC[i].expErr &&
          (!VEC[i].expValid || (rspTag == VEC[i].expTag && rspData == VEC[i].expData)),
          $sformatf("table vector %0d", i), {rspValid, errFlag, 14'd0, rspTag, rspData[31:0]},
          {VEC[i].expValid, VEC[i].expErr, 14'd0, VEC[i].expTag, VEC[i].expData[31:0]});
    end

    // R3: early readers get no reply
    drive(3'd0, 4'd7, 64'h0, 16'h21); expectNone("R3 early reader 1");
    drive(3'd0, 4'd7, 64'h0, 16'h22); expectNone("R3 early reader 2");
    drive(3'd0, 4'd7, 64'h0, 16'h23); expectNone("R3 early reader 3");
    // R4: release in arrival order
    drive(3'd1, 4'd7, 64'h77, 16'h0);
    expectNone("R4 gap cycle");
    chk(!reqReady, "R4 ready low in release", 64'(reqReady), 64'd0);
    @(negedge clk); expectReply("R4 first reader", 16'h21, 64'h77);
    chk(!reqReady, "R4 ready low mid release", 64'(reqReady), 64'd0);
    @(negedge clk); expectReply("R4 second reader", 16'h22, 64'h77);
    @(negedge clk); expectReply("R4 third reader", 16'h23, 64'h77);
    chk(reqReady, "R4 ready back", 64'(reqReady), 64'd1);
    @(negedge clk); expectNone("R4 no extra reply");
    drive(3'd0, 4'd7, 64'h0, 16'h24); expectReply("R4 word now full", 16'h24, 64'h77);

    // R9: fill pool on address 5
    for (int k = 0; k < 4; k++) begin
      drive(3'd0, 4'd5, 64'h0, 16'(16'h31 + k));
      expectNone("R9 waiting reader");
    end
    @(negedge clk);
    reqOp = 3'd0; reqAddr = 4'd5; reqTag = 16'h35; reqValid = 1'b1;
    #1 chk(!reqReady, "R9 deferring fetch held", 64'(reqReady), 64'd0);
    reqOp = 3'd1; reqAddr = 4'd6; reqData = 64'h66;
    #1 chk(reqReady, "R9 other op still ready", 64'(reqReady), 64'd1);
    @(negedge clk);
    reqValid = 1'b0;
    // R8: clear drops waiting readers silently and frees pool
    drive(3'd4, 4'd5, 64'h0, 16'h0);
    for (int k = 0; k < 5; k++) begin
      expectNone("R8 no reply for dropped reader");
      @(negedge clk);
    end
    chk(reqReady, "R8 idle after clear", 64'(reqReady), 64'd1);
    drive(3'd0, 4'd5, 64'h0, 16'h36); expectNone("R8 fetch after clear waits");
    drive(3'd1, 4'd5, 64'h55, 16'h0); expectNone("R8 gap cycle");
    @(negedge clk); expectReply("R8 only new reader answered", 16'h36, 64'h55);
    @(negedge clk); expectNone("R8 dropped readers stay dropped");
    drive(3'd0, 4'd6, 64'h0, 16'h37); expectReply("R9 store during full pool landed", 16'h37, 64'h66);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule